// File: doc/BRIEF.md
# Pipelined Burst Static Memory

A synchronous single-port memory with 18-bit words split into two 9-bit byte lanes. Address, write data, byte controls, chip selects and burst controls are all captured on the rising clock edge. A burst opens when either of two load strobes is low, which latches a fresh base address and the chip-select state. A 2-bit step counter then walks the three remaining words of the aligned group of four while the step input is held low. The order of the walk is either a wrap-around count or an XOR pattern, picked by the order input.

Reads leave through an output register. The first word of a burst therefore reaches the pads two edges after its request, and each further word follows one clock later. Writes go through a one-entry write buffer. A read that arrives on the very next cycle merges the buffered bytes over the array contents, so freshly written data is always visible. The pad driver is enabled only while output enable is low and registered read data is pending. That enable reacts to the output-enable input at once, without waiting for a clock.

Top module: `burst_sram`

## Requirements
- R1: A read requested in the cycle before rising edge n appears on `q` with `q_oe` high after edge n+1. A burst then delivers one new word per clock (3-1-1-1 pattern).
- R2: `ld_a_n` low or `ld_b_n` low at an edge loads `addr` as burst base, resets the step counter to 0 and latches the chip-select state. While no strobe or step follows, the same address keeps being accessed.
- R3: The step counter advances by one only at an edge with both strobes high, `step_n` low and the chip selected. Otherwise it holds.
- R4: With `order` = 0 the two low address bits equal (base low bits + count) mod 4. The upper address bits stay those of the base.
- R5: With `order` = 1 the two low address bits equal base low bits XOR count.
- R6: With `all_wr_n` high and `bytes_wr_n` low, `lo_wr_n` low writes bits 8:0 and `hi_wr_n` low writes bits 17:9. With `bytes_wr_n` high, the per-lane enables are ignored and the cycle is a read.
- R7: `all_wr_n` low writes both lanes whatever `bytes_wr_n`, `lo_wr_n` and `hi_wr_n` are.
- R8: A read of the location written in the immediately preceding cycle returns the new bytes merged with the unwritten bytes.
- R9: `q_oe` = not `oe_n` AND read data pending, and it follows `oe_n` combinationally. While `q_oe` is low, `q` is zero.
- R10: A load with any chip enable inactive (`en_a_n` high, `en_b` low or `en_c_n` high) makes no access and no write until the next load. `q_oe` falls after the edge following the deselecting load.
- R11: While `rst_n` is low the block is deselected and `q_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | External word address |
| ld_a_n | input | 1 | Load strobe A, active low |
| ld_b_n | input | 1 | Load strobe B, active low |
| step_n | input | 1 | Burst step request, active low |
| order | input | 1 | Burst order: 0 wrap count, 1 XOR |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| all_wr_n | input | 1 | Whole-word write, active low |
| bytes_wr_n | input | 1 | Qualifier for lane enables, active low |
| lo_wr_n | input | 1 | Lane 0 (bits 8:0) write enable, active low |
| hi_wr_n | input | 1 | Lane 1 (bits 17:9) write enable, active low |
| din | input | 18 | Write data |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| q | output | 18 | Read data, zero when not driven |
| q_oe | output | 1 | Pad driver enable for `q` |

## Verification
The hardest case to reach from the ports is a read that hits the write buffer while only one lane of the buffered write is enabled. In that case the returned word must mix the buffered lane with the older lane still in the array. The stimulus first fills a group of four words with whole-word writes. It then issues a lane-0-only write, followed at once by a read of the same address, so the buffer has not yet drained when the merge happens. Wrap-around and XOR orders are reached by starting bursts at non-zero offsets in the group. The held-address and deselected cases are reached by withholding the step input and dropping a chip enable.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    localparam int BYTE_W = 9;
    localparam int NBYTE  = 2;
    localparam int WORD_W = BYTE_W * NBYTE;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NBYTE-1:0]  be_t;

    typedef enum logic {
        ORD_WRAP = 1'b0,
        ORD_XOR  = 1'b1
    } order_e;
endpackage

// File: rtl/bsram_wmask.sv
module bsram_wmask
    import bsram_pkg::*;
(
    input  logic all_wr_n,
    input  logic bytes_wr_n,
    input  logic lo_wr_n,
    input  logic hi_wr_n,
    output be_t  be
);
    logic [NBYTE-1:0] lane_n;

    assign lane_n = {hi_wr_n, lo_wr_n};

    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        // whole-word write overrides; lane enables need the qualifier
        assign be[b] = !all_wr_n || (!bytes_wr_n && !lane_n[b]);
    end
endmodule

// File: rtl/bsram_seq.sv
module bsram_seq
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ld_a_n,
    input  logic          ld_b_n,
    input  logic          step_n,
    input  logic          order,
    input  logic          sel,
    input  be_t           be_in,
    input  word_t         din,
    output logic          req_rd,
    output be_t           req_be,
    output logic [AW-1:0] req_addr,
    output word_t         req_data,
    output logic [1:0]    cnt
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [1:0]    cnt;
        logic          act;
        logic          rd;
        be_t           be;
        logic [AW-1:0] a;
        word_t         d;
    } seq_st_t;

    seq_st_t s_d, s_q;
    logic    load;
    logic [1:0] low;

    assign load = !ld_a_n || !ld_b_n;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.base = addr;
            s_d.cnt  = 2'd0;
            s_d.act  = sel;
        end else if (s_q.act && !step_n) begin
            s_d.cnt = s_q.cnt + 2'd1;
        end
        if (order_e'(order) == ORD_XOR) low = s_d.base[1:0] ^ s_d.cnt;
        else                            low = s_d.base[1:0] + s_d.cnt;
        s_d.a  = {s_d.base[AW-1:2], low};
        s_d.be = s_d.act ? be_in : '0;
        s_d.rd = s_d.act && (be_in == '0);
        s_d.d  = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_rd   = s_q.rd;
    assign req_be   = s_q.be;
    assign req_addr = s_q.a;
    assign req_data = s_q.d;
    assign cnt      = s_q.cnt;
endmodule

// File: rtl/bsram_store.sv
module bsram_store
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  be_t           be,
    input  logic [AW-1:0] a,
    input  word_t         d,
    output word_t         q_word,
    output logic          drv
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic          wv;
        logic [AW-1:0] wa;
        word_t         wd;
        be_t           wb;
        word_t         q;
        logic          drv;
    } st_st_t;

    st_st_t s_d, s_q;
    word_t  mem [DEPTH];
    word_t  rdata;

    always_comb begin
        rdata = mem[a];
        for (int b = 0; b < NBYTE; b++) begin
            if (s_q.wv && (s_q.wa == a) && s_q.wb[b])
                rdata[b*BYTE_W +: BYTE_W] = s_q.wd[b*BYTE_W +: BYTE_W];
        end
        s_d     = s_q;
        s_d.q   = rd ? rdata : s_q.q;
        s_d.drv = rd;
        s_d.wv  = (be != '0);
        s_d.wa  = a;
        s_d.wd  = d;
        s_d.wb  = be;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // buffered write drains into the array one edge after capture
    always_ff @(posedge clk) begin
        for (int b = 0; b < NBYTE; b++) begin
            if (s_q.wv && s_q.wb[b])
                mem[s_q.wa][b*BYTE_W +: BYTE_W] <= s_q.wd[b*BYTE_W +: BYTE_W];
        end
    end

    assign q_word = s_q.q;
    assign drv    = s_q.drv;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              ld_a_n,
    input  logic              ld_b_n,
    input  logic              step_n,
    input  logic              order,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              all_wr_n,
    input  logic              bytes_wr_n,
    input  logic              lo_wr_n,
    input  logic              hi_wr_n,
    input  logic [WORD_W-1:0] din,
    input  logic              oe_n,
    output logic [WORD_W-1:0] q,
    output logic              q_oe
);
    logic          sel;
    be_t           be_in;
    logic          req_rd;
    be_t           req_be;
    logic [AW-1:0] req_addr;
    word_t         req_data;
    logic [1:0]    burst_cnt;
    word_t         q_word;
    logic          drv;

    assign sel = !en_a_n && en_b && !en_c_n;

    bsram_wmask u_wmask (
        .all_wr_n   (all_wr_n),
        .bytes_wr_n (bytes_wr_n),
        .lo_wr_n    (lo_wr_n),
        .hi_wr_n    (hi_wr_n),
        .be         (be_in)
    );

    bsram_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .ld_a_n   (ld_a_n),
        .ld_b_n   (ld_b_n),
        .step_n   (step_n),
        .order    (order),
        .sel      (sel),
        .be_in    (be_in),
        .din      (din),
        .req_rd   (req_rd),
        .req_be   (req_be),
        .req_addr (req_addr),
        .req_data (req_data),
        .cnt      (burst_cnt)
    );

    bsram_store #(.AW(AW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (req_rd),
        .be     (req_be),
        .a      (req_addr),
        .d      (req_data),
        .q_word (q_word),
        .drv    (drv)
    );

    assign q_oe = !oe_n && drv;
    assign q    = q_oe ? q_word : '0;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ld_a_n,
    input logic       ld_b_n,
    input logic       step_n,
    input logic       oe_n,
    input logic       sel,
    input logic       req_rd,
    input logic [1:0] req_be,
    input logic       drv,
    input logic [1:0] cnt,
    input logic       q_oe
);
    AST_LOAD_ZEROES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_a_n || !ld_b_n) |=> (cnt == 2'd0)); // R2

    AST_IDLE_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a_n && ld_b_n && step_n) |=> $stable(cnt)); // R3

    AST_READ_REACHES_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        req_rd |=> drv); // R1

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_be != 2'b00) |=> !drv); // R6

    AST_DESELECT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ld_a_n || !ld_b_n) && !sel) |=> (!req_rd && req_be == 2'b00)); // R10

    AST_OE_BLOCKS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !q_oe); // R9
endmodule

bind burst_sram bsram_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_a_n (ld_a_n),
    .ld_b_n (ld_b_n),
    .step_n (step_n),
    .oe_n   (oe_n),
    .sel    (sel),
    .req_rd (req_rd),
    .req_be (req_be),
    .drv    (drv),
    .cnt    (burst_cnt),
    .q_oe   (q_oe)
);

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ld_a_n, ld_b_n, step_n, order;
    logic          en_a_n, en_b, en_c_n;
    logic          all_wr_n, bytes_wr_n, lo_wr_n, hi_wr_n;
    logic [17:0]   din;
    logic          oe_n;
    logic [17:0]   q;
    logic          q_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    burst_sram #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ld_a_n(ld_a_n), .ld_b_n(ld_b_n),
        .step_n(step_n), .order(order), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .all_wr_n(all_wr_n), .bytes_wr_n(bytes_wr_n), .lo_wr_n(lo_wr_n),
        .hi_wr_n(hi_wr_n), .din(din), .oe_n(oe_n), .q(q), .q_oe(q_oe)
    );

    typedef struct packed {
        logic        lda_n, ldb_n, stp_n, ord;
        logic        all_n, byt_n, hi_n, lo_n, sel;
        logic [5:0]  a;
        logic [17:0] d;
        logic        eoe;
        logic [17:0] eq;
        logic [3:0]  req;
    } vec_t;

    // expected outputs after each row's edge reflect the previous row's request
    localparam vec_t VEC [30] = '{
        '{1,0,1,0, 0,1,1,1,1, 6'h08, 18'h12345, 0, 18'h0,     4'd11}, // R11 idle
        '{1,0,1,0, 0,1,1,1,1, 6'h09, 18'h0ABCD, 0, 18'h0,     4'd7},  // R7 fill
        '{1,0,1,0, 0,1,1,1,1, 6'h0A, 18'h3C3C3, 0, 18'h0,     4'd7},
        '{1,0,1,0, 0,1,1,1,1, 6'h0B, 18'h25A5A, 0, 18'h0,     4'd7},
        '{1,0,1,0, 1,1,1,1,1, 6'h08, 18'h0,     0, 18'h0,     4'd1},  // R1 latency
        '{1,1,0,0, 1,1,1,1,1, 6'h00, 18'h0,     1, 18'h12345, 4'd1},
        '{1,1,0,0, 1,1,1,1,1, 6'h00, 18'h0,     1, 18'h0ABCD, 4'd4},  // R4
        '{1,1,0,0, 1,1,1,1,1, 6'h00, 18'h0,     1, 18'h3C3C3, 4'd4},
        '{1,1,0,0, 1,1,1,1,1, 6'h00, 18'h0,     1, 18'h25A5A, 4'd4},
        '{0,1,1,0, 1,1,1,1,1, 6'h0A, 18'h0,     1, 18'h12345, 4'd4},  // R2 strobe A
        '{1,1,0,0, 1,1,1,1,1, 6'h00, 18'h0,     1, 18'h3C3C3, 4'd2},
        '{1,1,0,0, 1,1,1,1,1, 6'h00, 18'h0,     1, 18'h25A5A, 4'd4},
        '{1,1,0,0, 1,1,1,1,1, 6'h00, 18'h0,     1, 18'h12345, 4'd4},
        '{1,0,1,1, 1,1,1,1,1, 6'h09, 18'h0,     1, 18'h0ABCD, 4'd4},
        '{1,1,0,1, 1,1,1,1,1, 6'h00, 18'h0,     1, 18'h0ABCD, 4'd5},  // R5
        '{1,1,0,1, 1,1,1,1,1, 6'h00, 18'h0,     1, 18'h12345, 4'd5},
        '{1,1,0,1, 1,1,1,1,1, 6'h00, 18'h0,     1, 18'h25A5A, 4'd5},
        '{1,1,1,1, 1,1,1,1,1, 6'h00, 18'h0,     1, 18'h3C3C3, 4'd5},
        '{1,1,1,1, 1,1,1,1,1, 6'h00, 18'h0,     1, 18'h3C3C3, 4'd3},  // R3 hold
        '{1,0,1,1, 1,0,1,0,1, 6'h0A, 18'h155AA, 1, 18'h3C3C3, 4'd3},  // R6 lane 0
        '{1,0,1,0, 1,1,1,1,1, 6'h0A, 18'h0,     0, 18'h0,     4'd6},
        '{1,0,1,0, 1,0,0,1,1, 6'h0B, 18'h0,     1, 18'h3C3AA, 4'd8},  // R8 merge
        '{1,0,1,0, 1,1,1,1,1, 6'h0B, 18'h0,     0, 18'h0,     4'd6},
        '{1,0,1,0, 0,0,1,1,1, 6'h0B, 18'h3FFFF, 1, 18'h0005A, 4'd6},  // R6 lane 1
        '{1,0,1,0, 1,0,1,1,1, 6'h0B, 18'h0,     0, 18'h0,     4'd7},
        '{1,0,1,0, 1,1,0,0,1, 6'h08, 18'h0,     1, 18'h3FFFF, 4'd7},  // R7 override
        '{1,0,1,0, 1,1,1,1,0, 6'h08, 18'h0,     1, 18'h12345, 4'd6},  // R6 ignored
        '{1,1,0,0, 1,1,1,1,1, 6'h00, 18'h0,     0, 18'h0,     4'd10}, // R10
        '{0,1,1,0, 1,1,1,1,1, 6'h09, 18'h0,     0, 18'h0,     4'd10},
        '{1,1,1,0, 1,1,1,1,1, 6'h00, 18'h0,     1, 18'h0ABCD, 4'd2}
    };

    task automatic check(input logic eoe, input logic [17:0] eq, input int r);
        n_chk++;
        if (q_oe !== eoe || q !== eq) begin
            n_bad++;
            $display("FAIL R%0d: q_oe=%0b q=%05h expected q_oe=%0b q=%05h",
                     r, q_oe, q, eoe, eq);
        end
    endtask

    task automatic idle_inputs();
        ld_a_n = 1; ld_b_n = 1; step_n = 1; order = 0;
        en_a_n = 0; en_b = 1; en_c_n = 0;
        all_wr_n = 1; bytes_wr_n = 1; lo_wr_n = 1; hi_wr_n = 1;
        addr = '0; din = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        oe_n  = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #2 check(1'b0, 18'h0, 11); // R11 reset state
        @(negedge clk) rst_n = 1;

        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            ld_a_n = VEC[i].lda_n; ld_b_n = VEC[i].ldb_n; step_n = VEC[i].stp_n;
            order = VEC[i].ord; all_wr_n = VEC[i].all_n; bytes_wr_n = VEC[i].byt_n;
            hi_wr_n = VEC[i].hi_n; lo_wr_n = VEC[i].lo_n;
            en_a_n = !VEC[i].sel; en_b = 1; en_c_n = 0;
            addr = VEC[i].a; din = VEC[i].d;
            @(posedge clk);
            #2 check(VEC[i].eoe, VEC[i].eq, int'(VEC[i].req));
        end

        // R9: output enable acts without a clock edge
        @(negedge clk);
        idle_inputs(); ld_b_n = 0; addr = 6'h0B;
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        #2 check(1'b1, 18'h3FFFF, 1); // R1
        oe_n = 1;
        #1 check(1'b0, 18'h0, 9);     // R9 off
        oe_n = 0;
        #1 check(1'b1, 18'h3FFFF, 9); // R9 on

        // R10: active-high enable low deselects
        @(negedge clk);
        idle_inputs(); ld_b_n = 0; addr = 6'h08; en_b = 0;
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        #2 check(1'b0, 18'h0, 10);    // R10

        // R11: reset mid-operation
        @(negedge clk);
        idle_inputs(); ld_b_n = 0; addr = 6'h09;
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        #2 check(1'b1, 18'h0ABCD, 1);
        rst_n = 0;
        #1 check(1'b0, 18'h0, 11);    // R11

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule